// File: doc/BRIEF.md
# Reciprocal-Multiply Execution Unit

This unit carries out an integer instruction that scales a 64-bit destination value by the fixed-point reciprocal of a 32-bit unsigned immediate. The immediate stands in for a constant divisor. The unit first builds the reciprocal `rcp = floor(2^x / imm)`, where `x` is the largest exponent that keeps `rcp` below 2^64. It then multiplies the destination by `rcp` and returns the low 64 bits of the product with a write-enable.

A caller pulses `start` for one cycle and supplies the destination value and the immediate in that cycle. The unit latches both operands. A shift-subtract divider then produces one quotient bit per clock for 64 clocks. In the following clock the product is registered, and `done` pulses with `wr_en` high. A zero immediate makes the instruction a no-op. In that case the divider is skipped, `done` pulses in the next cycle with `wr_en` low, and `result` echoes the untouched destination value.

Top module: `rcpmul_unit`

## Requirements
- R1: For a nonzero immediate, the cycle in which `done` is high carries `wr_en` high and `result` equal to the low 64 bits of `dst_in * rcp`, using the operands sampled with the accepted `start`.
- R2: `rcp` is `floor(2^x / imm)`, with `imm` zero-extended and unsigned and `x` the largest integer for which `rcp < 2^64`. As a result, bit 63 of `rcp` is always set.
- R3: When the immediate is a power of two (including 1), `rcp` is exactly 2^63, so `result` is `{dst_in[0], 63'b0}`.
- R4: When the immediate is not a power of two (for example 0xFFFFFFFF or 3), `rcp` lies strictly between 2^63 and 2^64.
- R5: A start with a zero immediate raises `done` in the next cycle with `wr_en` low and `result` equal to the sampled `dst_in`. `busy` stays low.
- R6: `done` lasts one cycle per accepted start, and `wr_en` is never high without `done`.
- R7: A start with a nonzero immediate makes `busy` high from the next cycle until `done`. `done` appears 66 rising edges after the edge that sampled `start`, counting that edge as the first of the 66. `busy` falls in the same edge that raises `done`.
- R8: A `start` while `busy` is high is ignored. It causes no extra `done` and does not alter the result of the operation in flight.
- R9: After reset, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; accepted only while idle |
| dst_in | input | 64 | Destination operand, sampled with an accepted start |
| imm_in | input | 32 | Unsigned immediate divisor, sampled with an accepted start |
| busy | output | 1 | Operation in progress; new starts ignored |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Value to write back, valid while done is high |
| wr_en | output | 1 | Write-back enable, high only with done for a nonzero immediate |

## Verification
A wrong quotient bit or a wrongly seeded remainder in the divider does not show at the ports until the completion pulse, 66 edges after the start. At that point it appears as a wrong `result`, and the scoreboard compares that value against a wide-integer model that searches for the exponent directly. A miscounting iteration counter or a wrong state shows as `done` arriving at a latency other than 66, or as `busy` dropping without `done`. A start that is accepted while busy shows as an unexpected completion pulse with nothing queued. A broken zero test shows as `wr_en` asserting, or as a 66-cycle latency where a 1-cycle one was expected.

// File: rtl/rcpmul_pkg.sv
package rcpmul_pkg;
  typedef enum logic {RM_IDLE, RM_DIV} rm_state_e;

  // low half of an unsigned product, kept here so the top stays readable
  function automatic logic [63:0] low_mul64(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] full;
    full = {64'd0, a} * {64'd0, b};
    return full[63:0];
  endfunction
endpackage

// File: rtl/rcpmul_scan.sv
module rcpmul_scan #(
  parameter int IMM_W = 32,
  localparam int IDX_W = $clog2(IMM_W)
) (
  input  logic [IMM_W-1:0] imm,
  output logic [IDX_W-1:0] lead_idx,
  output logic             pow2,
  output logic             zero
);
  always_comb begin
    lead_idx = '0;
    for (int i = 0; i < IMM_W; i++) begin
      if (imm[i]) lead_idx = IDX_W'(i);
    end
  end

  assign zero = (imm == '0);
  assign pow2 = !zero && ((imm & (imm - IMM_W'(1))) == '0);
endmodule

// File: rtl/rcpmul_divider.sv
module rcpmul_divider #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  localparam int IDX_W = $clog2(IMM_W),
  localparam int REM_W = IMM_W + 1,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IMM_W-1:0]  divisor,
  input  logic [IDX_W-1:0]  lead_idx,
  input  logic              pow2_in,
  output logic              running,
  output logic [DATA_W-1:0] rcp
);
  logic [REM_W-1:0]  rem_q;
  logic [DATA_W-1:0] quot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IMM_W-1:0]  div_q;
  logic              pow2_q;

  logic [REM_W-1:0] rem_dbl, rem_nxt, div_ext, seed;
  logic             bit_ge;

  // the remainder starts at 2^k, the dividend bits above the low DATA_W zeros
  assign seed    = REM_W'(1) << lead_idx;
  assign div_ext = {1'b0, div_q};
  assign rem_dbl = {rem_q[REM_W-2:0], 1'b0};
  assign bit_ge  = (rem_dbl >= div_ext);
  assign rem_nxt = bit_ge ? (rem_dbl - div_ext) : rem_dbl;
  assign running = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quot_q <= '0;
      cnt_q  <= '0;
      div_q  <= '0;
      pow2_q <= 1'b0;
    end else if (load) begin
      rem_q  <= pow2_in ? '0 : seed;
      quot_q <= '0;
      cnt_q  <= CNT_W'(DATA_W);
      div_q  <= divisor;
      pow2_q <= pow2_in;
    end else if (running) begin
      rem_q  <= rem_nxt;
      quot_q <= {quot_q[DATA_W-2:0], bit_ge};
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  // an exact power of two would give 2^DATA_W at x = DATA_W + k; one less exponent gives 2^(DATA_W-1)
  assign rcp = pow2_q ? {1'b1, {(DATA_W-1){1'b0}}} : quot_q;
endmodule

// File: rtl/rcpmul_unit.sv
module rcpmul_unit #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32,
  localparam int IDX_W = $clog2(IMM_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [IMM_W-1:0]  imm_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              wr_en
);
  import rcpmul_pkg::*;

  rm_state_e         state_q;
  logic [DATA_W-1:0] dst_q;
  logic [IDX_W-1:0]  lead_idx;
  logic              imm_pow2, imm_zero;
  logic              div_running;
  logic [DATA_W-1:0] rcp;

  // named events for the checker
  logic accept, zero_go, div_go, mul_fire;

  rcpmul_scan #(.IMM_W(IMM_W)) u_scan (
    .imm      (imm_in),
    .lead_idx (lead_idx),
    .pow2     (imm_pow2),
    .zero     (imm_zero)
  );

  rcpmul_divider #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (div_go),
    .divisor  (imm_in),
    .lead_idx (lead_idx),
    .pow2_in  (imm_pow2),
    .running  (div_running),
    .rcp      (rcp)
  );

  assign accept   = start && (state_q == RM_IDLE);
  assign zero_go  = accept && imm_zero;
  assign div_go   = accept && !imm_zero;
  assign mul_fire = (state_q == RM_DIV) && !div_running;
  assign busy     = (state_q == RM_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RM_IDLE;
      dst_q   <= '0;
      done    <= 1'b0;
      wr_en   <= 1'b0;
      result  <= '0;
    end else begin
      done  <= zero_go || mul_fire;
      wr_en <= mul_fire;
      if (div_go) begin
        state_q <= RM_DIV;
        dst_q   <= dst_in;
      end else if (mul_fire) begin
        state_q <= RM_IDLE;
      end
      if (zero_go)       result <= dst_in;
      else if (mul_fire) result <= DATA_W'(low_mul64(64'(dst_q), 64'(rcp)));
    end
  end
endmodule

// File: rtl/rcpmul_unit_chk.sv
module rcpmul_unit_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [DATA_W-1:0] dst_in,
  input logic [IMM_W-1:0]  imm_in,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic [DATA_W-1:0] result,
  input logic              mul_fire,
  input logic [DATA_W-1:0] rcp
);
  AST_WR_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> done); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && imm_in == '0)) |=> !done); // R6
  AST_ZERO_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && imm_in == '0) |=> (done && !wr_en && !busy && result == $past(dst_in))); // R5
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && wr_en)); // R7
  AST_RCP_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fire |-> rcp[DATA_W-1]); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mul_fire) |=> (busy && !done)); // R8
endmodule

bind rcpmul_unit rcpmul_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dst_in(dst_in), .imm_in(imm_in),
  .busy(busy), .done(done), .wr_en(wr_en), .result(result),
  .mul_fire(mul_fire), .rcp(rcp)
);

// File: tb/sim_rcpmul_unit.sv
module sim_rcpmul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] dst_in = '0;
  logic [31:0] imm_in = '0;
  logic        busy, done, wr_en;
  logic [63:0] result;

  always #10 clk = ~clk; // 50 MHz

  rcpmul_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_in(dst_in), .imm_in(imm_in),
    .busy(busy), .done(done), .result(result), .wr_en(wr_en)
  );

  typedef struct {
    logic [63:0] exp_res;
    logic        exp_wr;
    longint      issue_cyc;
    longint      lat;
    string       tag;
  } item_t;

  item_t  sb[$];
  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  bit     finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // search the exponent from the top: first x with floor(2^x/m) < 2^64
  function automatic logic [63:0] ref_rcp(input logic [31:0] m);
    logic [127:0] q;
    logic [63:0]  r;
    r = '0;
    for (int x = 100; x >= 0; x--) begin
      q = (128'd1 << x) / {96'd0, m};
      if (q[127:64] == '0) begin
        r = q[63:0];
        break;
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_result(input logic [63:0] d, input logic [31:0] m);
    logic [127:0] p;
    if (m == 0) return d;
    p = {64'd0, d} * {64'd0, ref_rcp(m)};
    return p[63:0];
  endfunction

  task automatic issue(input logic [63:0] d, input logic [31:0] m, input string tag, input int noise);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; dst_in = d; imm_in = m;
    it.exp_res = ref_result(d, m);
    it.exp_wr = (m != 0);
    it.issue_cyc = cyc;
    it.lat = (m != 0) ? 66 : 1;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    if (m != 0) chk(busy === 1'b1, "R7 busy after start", 64'(busy), 64'd1);
    else        chk(busy === 1'b0, "R5 busy stays low", 64'(busy), 64'd0);
    // R8: starts while busy, with a zero immediate that would complete at once if taken
    for (int i = 0; i < noise; i++) begin
      dst_in = {$urandom, $urandom}; imm_in = '0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wr_en && !done) chk(1'b0, "R6 wr_en without done", 64'(wr_en), 64'd0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8/R6 unexpected done", 64'(done), 64'd0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(result === it.exp_res, {it.tag, " result"}, result, it.exp_res);
          chk(wr_en === it.exp_wr, {it.tag, " wr_en (R1/R5)"}, 64'(wr_en), 64'(it.exp_wr));
          chk((cyc - it.issue_cyc) == it.lat, {it.tag, " latency (R7/R5)"}, 64'(cyc - it.issue_cyc), 64'(it.lat));
        end
      end
    end
  end

  // watchdog
  initial begin
    while (cyc < 150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 64'(cyc), 64'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R9 busy", 64'(busy), 64'd0);
    chk(done === 1'b0, "R9 done", 64'(done), 64'd0);
    chk(wr_en === 1'b0, "R9 wr_en", 64'(wr_en), 64'd0);
    rst_n = 1'b1;
    // R2 self-check of the model range on a known value: imm=3 -> floor(2^65/3)
    chk(ref_rcp(32'd3) == 64'hAAAA_AAAA_AAAA_AAAA, "R4 model imm=3", ref_rcp(32'd3), 64'hAAAA_AAAA_AAAA_AAAA);
    issue(64'h0123_4567_89AB_CDEF, 32'd1, "R3 imm=1", 0);
    issue(64'hFFFF_FFFF_FFFF_FFFE, 32'd1, "R3 imm=1 even dst", 0);
    issue(64'hDEAD_BEEF_0000_0001, 32'h8000_0000, "R3 imm=2^31", 0);
    issue(64'h0000_0000_0000_0003, 32'd16, "R3 imm=16", 0);
    issue(64'h1357_9BDF_2468_ACE0, 32'hFFFF_FFFF, "R4 imm=max", 0);
    issue(64'd1, 32'hFFFF_FFFF, "R2 dst=1 exposes rcp", 0);
    issue(64'd1, 32'd3, "R2 dst=1 imm=3", 0);
    issue(64'h7777_0000_1111_2222, 32'd0, "R5 zero imm", 0);
    issue(64'hAAAA_5555_AAAA_5555, 32'd0, "R5 zero imm back-to-back", 0);
    issue(64'h0F0F_F0F0_1234_5678, 32'd1000, "R8 noisy start", 3);
    for (int n = 0; n < 20; n++) begin
      logic [31:0] m;
      m = $urandom;
      if (n % 5 == 0) m = m >> (n % 31);
      issue({$urandom, $urandom}, m, "R1 random", (n % 4 == 0) ? 2 : 0);
    end
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R6 scoreboard drained", 64'(sb.size()), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule